// File: doc/BRIEF.md
# Command-Decoded Display Controller Register File

This block sits behind a byte-wide host link and turns a stream of command bytes into register updates and read responses for a small character-display controller. Each transaction starts with an instruction byte. The top two bits of that byte mark it as an instruction. One bit chooses read or write, and the low five bits name a register. A write instruction takes the next byte on the link as its data. A read instruction produces a one-cycle response on the read port and does not use a data byte.

The block holds the following state:

- a 16 x 16 byte display memory, addressed by a column pointer and a row pointer;
- two control registers;
- four general-purpose port registers;
- a contrast value;
- three PWM duty registers.

After every display memory access, one of the two pointers advances automatically. A control bit chooses which one. The pointer that advances wraps from 15 back to 0. The block can also return the live key-scan inputs, and it can return an external rotary count sign-extended to a full byte.

Top module: `dispctl_regfile`

## Requirements
- R1: A byte accepted while no write is pending is an instruction only if bits 7:6 are 2'b11. Bit 5 = 1 means read and bit 5 = 0 means write. Bits 4:0 give the register number. Any other byte in that state is ignored.
- R2: Register 2 (column pointer) and register 3 (row pointer) load bits 3:0 of the data byte. Bits 7:4 are ignored.
- R3: Each display memory access (a write of register 1, or a read of register 1) advances one pointer and leaves the other unchanged. When control-1 bit 7 is 1, the column pointer advances. When that bit is 0, the row pointer advances. The pointer wraps from 15 to 0.
- R4: A write of register 1 stores the byte at memory location (row, column). A later read of register 1 at the same location returns that byte.
- R5: When control-1 bit 6 is 1, memory writes store bits 7:6 as 0 and memory reads return bits 7:6 as 0.
- R6: The control-1 fields from bit 7 down to bit 0 are: pointer axis, narrow word, slow key scan, common reverse, doubler enable, port enable, and duty[1:0]. Each field drives its own output. Control-2 (register 8 is control-1, register 9 is control-2) bit 0 drives display on.
- R7: Registers 4 to 7 are ports A to D, 1, 3, 5 and 5 bits wide. Register 11 is the contrast value, 4 bits wide. Each of these keeps the low bits of its data byte. Registers 12 to 14 are PWM 0 to 2, each a full byte, output as pwm_duty[8i+7:8i].
- R8: A read of register 0 returns key_timing in bits 7:5 and key_bits in bits 4:0.
- R9: A read of register 10 returns rot_count[3] in bits 7:3 and rot_count[2:0] in bits 2:0.
- R10: Writes to register 15, to registers 16 to 31, and to the read-only registers 0 and 10 change no state. A read of any register other than 0, 1 and 10 returns 0.
- R11: After reset, all registers, both pointers and every memory byte are 0, and the display is off.
- R12: rd_valid is 1 in the cycle after the clock edge that accepted a read instruction, and only then. A read instruction uses no data byte. The byte after a write instruction is always treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A byte is present on cmd_byte |
| cmd_byte | input | 8 | Instruction or data byte |
| key_timing | input | 3 | Key-scan timing bits |
| key_bits | input | 5 | Key-scan data bits |
| rot_count | input | 4 | Two's-complement rotary count |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Read response byte |
| addr_x | output | 4 | Column pointer |
| addr_y | output | 4 | Row pointer |
| ctl_inc | output | 1 | Pointer axis select (1 = column) |
| ctl_word6 | output | 1 | Narrow memory word select |
| ctl_key_slow | output | 1 | Slow key-scan period select |
| ctl_com_rev | output | 1 | Common drive direction reverse |
| ctl_dbl_en | output | 1 | Voltage doubler enable |
| ctl_port_en | output | 1 | General-purpose port enable |
| ctl_duty | output | 2 | Display duty select |
| disp_on | output | 1 | Display on |
| port_a | output | 1 | Port A data |
| port_b | output | 3 | Port B data |
| port_c | output | 5 | Port C data |
| port_d | output | 5 | Port D data |
| contrast | output | 4 | Contrast value |
| pwm_duty | output | 24 | PWM duty bytes, PWM 0 in the low byte |

## Verification
Some rules are checked on every cycle by assertions. Each memory access moves exactly one pointer, on the axis the control bit selects, while the other pointer holds its value. A response appears only after an accepted read instruction. A narrow-mode memory read has bits 7:6 clear. A rotary read response has bits 7:3 all equal. Reads of unreadable registers return zero. A pending write clears after one byte.

Other behaviour can only be shown by the bench scenarios, which compare against an independent model. These scenarios cover the following:
- memory contents read back at the right locations;
- wrap on both axes;
- the exact field order of control-1;
- the width truncation of the port and contrast registers;
- ignored non-instruction bytes;
- writes to the test register and undefined registers that leave every output unchanged.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int REG_W = 5;

    localparam logic [REG_W-1:0] RG_KEY  = 5'd0;
    localparam logic [REG_W-1:0] RG_MEM  = 5'd1;
    localparam logic [REG_W-1:0] RG_XA   = 5'd2;
    localparam logic [REG_W-1:0] RG_YA   = 5'd3;
    localparam logic [REG_W-1:0] RG_PA   = 5'd4;
    localparam logic [REG_W-1:0] RG_PB   = 5'd5;
    localparam logic [REG_W-1:0] RG_PC   = 5'd6;
    localparam logic [REG_W-1:0] RG_PD   = 5'd7;
    localparam logic [REG_W-1:0] RG_CTL1 = 5'd8;
    localparam logic [REG_W-1:0] RG_CTL2 = 5'd9;
    localparam logic [REG_W-1:0] RG_ROT  = 5'd10;
    localparam logic [REG_W-1:0] RG_CONT = 5'd11;
    localparam logic [REG_W-1:0] RG_PWM0 = 5'd12;

    // Control-1 layout, most significant field first
    typedef struct packed {
        logic       inc;
        logic       wls;
        logic       kt;
        logic       shl;
        logic       be;
        logic       pe;
        logic [1:0] duty;
    } ctl1_t;

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
    import dispctl_pkg::*;
(
    input  logic [7:0]       byte_in,
    output logic             is_instr,
    output logic             is_read,
    output logic [REG_W-1:0] reg_num
);
    always_comb begin
        is_instr = (byte_in[7:6] == 2'b11);
        is_read  = byte_in[5];
        reg_num  = byte_in[REG_W-1:0];
    end
endmodule

// File: rtl/dispctl_ptr.sv
module dispctl_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_x,
    input  logic          ld_y,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    input  logic          step_x,
    output logic [AW-1:0] x_q,
    output logic [AW-1:0] y_q
);
    typedef struct packed {
        logic [AW-1:0] x;
        logic [AW-1:0] y;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (ld_x) p_d.x = ld_val;
        if (ld_y) p_d.y = ld_val;
        if (step) begin
            if (step_x) p_d.x = p_q.x + 1'b1;
            else        p_d.y = p_q.y + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign x_q = p_q.x;
    assign y_q = p_q.y;
endmodule

// File: rtl/dispctl_mem.sv
module dispctl_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/dispctl_regfile.sv
module dispctl_regfile
    import dispctl_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int NW    = 6,
    parameter int PA_W  = 1,
    parameter int PB_W  = 3,
    parameter int PC_W  = 5,
    parameter int PD_W  = 5,
    parameter int CT_W  = 4,
    parameter int NPWM  = 3,
    parameter int KT_W  = 3,
    parameter int KEY_W = 5,
    parameter int RQ_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte,
    input  logic [KT_W-1:0]      key_timing,
    input  logic [KEY_W-1:0]     key_bits,
    input  logic [RQ_W-1:0]      rot_count,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic [AW-1:0]        addr_x,
    output logic [AW-1:0]        addr_y,
    output logic                 ctl_inc,
    output logic                 ctl_word6,
    output logic                 ctl_key_slow,
    output logic                 ctl_com_rev,
    output logic                 ctl_dbl_en,
    output logic                 ctl_port_en,
    output logic [1:0]           ctl_duty,
    output logic                 disp_on,
    output logic [PA_W-1:0]      port_a,
    output logic [PB_W-1:0]      port_b,
    output logic [PC_W-1:0]      port_c,
    output logic [PD_W-1:0]      port_d,
    output logic [CT_W-1:0]      contrast,
    output logic [NPWM*DW-1:0]   pwm_duty
);
    localparam int MAW = 2 * AW;
    localparam logic [DW-1:0] NARROW_MASK = DW'((1 << NW) - 1);

    typedef struct packed {
        logic                       pending;
        logic [REG_W-1:0]           pend_reg;
        ctl1_t                      ctl1;
        logic                       disp;
        logic [PA_W-1:0]            pa;
        logic [PB_W-1:0]            pb;
        logic [PC_W-1:0]            pc;
        logic [PD_W-1:0]            pd;
        logic [CT_W-1:0]            cont;
        logic [NPWM-1:0][DW-1:0]    pwm;
        logic                       rd_valid;
        logic [DW-1:0]              rd_data;
    } state_t;

    state_t st_d, st_q;

    logic             dec_instr, dec_read;
    logic [REG_W-1:0] dec_reg;
    logic [AW-1:0]    px, py;
    logic [DW-1:0]    mem_rdata, mem_rd_view, mem_wdata;
    logic             mem_we, mem_rd, ld_x, ld_y;

    dispctl_decode u_dec (
        .byte_in  (cmd_byte),
        .is_instr (dec_instr),
        .is_read  (dec_read),
        .reg_num  (dec_reg)
    );

    always_comb begin
        mem_we      = cmd_valid && st_q.pending && (st_q.pend_reg == RG_MEM);
        mem_rd      = cmd_valid && !st_q.pending && dec_instr && dec_read && (dec_reg == RG_MEM);
        ld_x        = cmd_valid && st_q.pending && (st_q.pend_reg == RG_XA);
        ld_y        = cmd_valid && st_q.pending && (st_q.pend_reg == RG_YA);
        mem_wdata   = st_q.ctl1.wls ? (cmd_byte & NARROW_MASK) : cmd_byte;
        mem_rd_view = st_q.ctl1.wls ? (mem_rdata & NARROW_MASK) : mem_rdata;
    end

    dispctl_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_x   (ld_x),
        .ld_y   (ld_y),
        .ld_val (cmd_byte[AW-1:0]),
        .step   (mem_we || mem_rd),
        .step_x (st_q.ctl1.inc),
        .x_q    (px),
        .y_q    (py)
    );

    dispctl_mem #(.AW(MAW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  ({py, px}),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.rd_data  = '0;
        if (cmd_valid) begin
            if (st_q.pending) begin
                st_d.pending = 1'b0;
                case (st_q.pend_reg)
                    RG_PA:   st_d.pa   = cmd_byte[PA_W-1:0];
                    RG_PB:   st_d.pb   = cmd_byte[PB_W-1:0];
                    RG_PC:   st_d.pc   = cmd_byte[PC_W-1:0];
                    RG_PD:   st_d.pd   = cmd_byte[PD_W-1:0];
                    RG_CTL1: st_d.ctl1 = ctl1_t'(cmd_byte);
                    RG_CTL2: st_d.disp = cmd_byte[0];
                    RG_CONT: st_d.cont = cmd_byte[CT_W-1:0];
                    default: ;
                endcase
                for (int i = 0; i < NPWM; i++) begin
                    if (st_q.pend_reg == RG_PWM0 + REG_W'(i)) st_d.pwm[i] = cmd_byte;
                end
            end else if (dec_instr) begin
                if (dec_read) begin
                    st_d.rd_valid = 1'b1;
                    case (dec_reg)
                        RG_KEY:  st_d.rd_data = {key_timing, key_bits};
                        RG_MEM:  st_d.rd_data = mem_rd_view;
                        RG_ROT:  st_d.rd_data = {{(DW-RQ_W+1){rot_count[RQ_W-1]}},
                                                 rot_count[RQ_W-2:0]};
                        default: st_d.rd_data = '0;
                    endcase
                end else begin
                    st_d.pending  = 1'b1;
                    st_d.pend_reg = dec_reg;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid     = st_q.rd_valid;
    assign rd_data      = st_q.rd_data;
    assign addr_x       = px;
    assign addr_y       = py;
    assign ctl_inc      = st_q.ctl1.inc;
    assign ctl_word6    = st_q.ctl1.wls;
    assign ctl_key_slow = st_q.ctl1.kt;
    assign ctl_com_rev  = st_q.ctl1.shl;
    assign ctl_dbl_en   = st_q.ctl1.be;
    assign ctl_port_en  = st_q.ctl1.pe;
    assign ctl_duty     = st_q.ctl1.duty;
    assign disp_on      = st_q.disp;
    assign port_a       = st_q.pa;
    assign port_b       = st_q.pb;
    assign port_c       = st_q.pc;
    assign port_d       = st_q.pd;
    assign contrast     = st_q.cont;
    assign pwm_duty     = st_q.pwm;
endmodule

// File: rtl/dispctl_regfile_chk.sv
module dispctl_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       pending,
    input logic [4:0] pend_reg,
    input logic       inc,
    input logic       word6,
    input logic [3:0] addr_x,
    input logic [3:0] addr_y,
    input logic       rd_valid,
    input logic [7:0] rd_data
);
    logic rd_instr, mem_touch, mem_read, rot_read, dead_read;

    always_comb begin
        rd_instr  = cmd_valid && !pending && (cmd_byte[7:5] == 3'b111);
        mem_read  = rd_instr && (cmd_byte[4:0] == 5'd1);
        rot_read  = rd_instr && (cmd_byte[4:0] == 5'd10);
        dead_read = rd_instr && (cmd_byte[4:0] != 5'd0) && (cmd_byte[4:0] != 5'd1)
                    && (cmd_byte[4:0] != 5'd10);
        mem_touch = mem_read || (cmd_valid && pending && (pend_reg == 5'd1));
    end

    // R12
    rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_instr));

    // R12
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && pending) |=> !pending);

    // R3
    step_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_touch && inc) |=> (addr_x == $past(addr_x) + 4'd1) && $stable(addr_y));

    // R3
    step_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_touch && !inc) |=> (addr_y == $past(addr_y) + 4'd1) && $stable(addr_x));

    // R5
    narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && word6) |=> (rd_data[7:6] == 2'b00));

    // R9
    rot_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_read |=> (rd_data[7:3] == 5'b00000 || rd_data[7:3] == 5'b11111));

    // R10
    dead_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dead_read |=> (rd_data == 8'h00));
endmodule

bind dispctl_regfile dispctl_regfile_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .pending   (st_q.pending),
    .pend_reg  (st_q.pend_reg),
    .inc       (ctl_inc),
    .word6     (ctl_word6),
    .addr_x    (addr_x),
    .addr_y    (addr_y),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/test_dispctl_regfile.sv
`timescale 1ns/1ps
module test_dispctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [2:0]  key_timing = 3'd0;
    logic [4:0]  key_bits = 5'd0;
    logic [3:0]  rot_count = 4'd0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [3:0]  addr_x, addr_y;
    logic        ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev, ctl_dbl_en, ctl_port_en;
    logic [1:0]  ctl_duty;
    logic        disp_on;
    logic [0:0]  port_a;
    logic [2:0]  port_b;
    logic [4:0]  port_c, port_d;
    logic [3:0]  contrast;
    logic [23:0] pwm_duty;

    always #5 clk = ~clk;

    dispctl_regfile i_dispctl_regfile (.*);

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [7:0] mdl [256];
    logic [3:0] mx = 0, my = 0;
    bit         minc = 0, mwls = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected response", rd_data, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] r, input logic [7:0] d);
        send({3'b110, r});
        send(d);
    endtask

    task automatic rd(input logic [4:0] r, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        send({3'b111, r});
    endtask

    task automatic mstep();
        if (minc) mx = mx + 1'b1;
        else      my = my + 1'b1;
    endtask

    task automatic mem_wr(input logic [7:0] d);
        mdl[{my, mx}] = mwls ? (d & 8'h3F) : d;
        mstep();
        wr(5'd1, d);
    endtask

    task automatic mem_rd(input string t);
        logic [7:0] e;
        e = mdl[{my, mx}];
        if (mwls) e = e & 8'h3F;
        mstep();
        rd(5'd1, e, t);
    endtask

    task automatic set_ctl1(input logic [7:0] v);
        minc = v[7];
        mwls = v[6];
        wr(5'd8, v);
    endtask

    task automatic chk_ptr(input string t);
        chk(addr_x == mx, t, addr_x, mx);
        chk(addr_y == my, t, addr_y, my);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk({addr_x, addr_y} == 8'h00, "R11 pointers", {addr_x, addr_y}, 0);
        chk({ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev, ctl_dbl_en, ctl_port_en, ctl_duty} == 8'h00,
            "R11 control1", {ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev, ctl_dbl_en, ctl_port_en, ctl_duty}, 0);
        chk(disp_on == 1'b0, "R11 display off", disp_on, 0);
        chk({port_a, port_b, port_c, port_d, contrast} == '0, "R11 ports", {port_a, port_b, port_c, port_d, contrast}, 0);
        chk(pwm_duty == 24'h0, "R11 pwm", pwm_duty, 0);
        chk(rd_valid == 1'b0, "R11 rd_valid", rd_valid, 0);
        rd(5'd1, 8'h00, "R11 memory cleared");

        // R2 pointer loads use the low nibble
        wr(5'd2, 8'h3A); mx = 4'hA;
        wr(5'd3, 8'hF5); my = 4'h5;
        chk_ptr("R2 pointer load");

        // R3/R4 column stepping with wrap
        set_ctl1(8'h80);
        for (int i = 0; i < 6; i++) mem_wr(8'h11 + 8'(i * 8'h23));
        chk_ptr("R3 column wrap");
        wr(5'd2, 8'h0A); mx = 4'hA;
        for (int i = 0; i < 6; i++) mem_rd("R4 readback column");
        chk_ptr("R3 column read step");

        // R3 row stepping with wrap
        set_ctl1(8'h00);
        wr(5'd2, 8'h02); mx = 4'h2;
        wr(5'd3, 8'h0E); my = 4'hE;
        mem_wr(8'hC4);
        mem_wr(8'h9B);
        chk_ptr("R3 row wrap");
        wr(5'd3, 8'h0E); my = 4'hE;
        mem_rd("R4 readback row");
        mem_rd("R4 readback row");

        // R5 narrow words
        set_ctl1(8'h40);
        wr(5'd3, 8'h07); my = 4'h7;
        mem_wr(8'hFF);
        wr(5'd3, 8'h07); my = 4'h7;
        mem_rd("R5 narrow write");
        wr(5'd2, 8'h0A); mx = 4'hA; wr(5'd3, 8'h05); my = 4'h5;
        mem_rd("R5 narrow read of wide word");
        set_ctl1(8'h00);
        wr(5'd3, 8'h07); my = 4'h7;
        mem_rd("R5 stored value has top bits clear");

        // R6 control field order
        set_ctl1(8'hA5);
        chk({ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev} == 4'b1010, "R6 upper fields",
            {ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev}, 4'b1010);
        chk({ctl_dbl_en, ctl_port_en, ctl_duty} == 4'b0101, "R6 lower fields",
            {ctl_dbl_en, ctl_port_en, ctl_duty}, 4'b0101);
        set_ctl1(8'h5A);
        chk({ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev, ctl_dbl_en, ctl_port_en, ctl_duty} == 8'h5A,
            "R6 inverse pattern", {ctl_inc, ctl_word6, ctl_key_slow, ctl_com_rev, ctl_dbl_en, ctl_port_en, ctl_duty}, 8'h5A);
        wr(5'd9, 8'hFF);
        chk(disp_on == 1'b1, "R6 display on", disp_on, 1);
        wr(5'd9, 8'hFE);
        chk(disp_on == 1'b0, "R6 display off by bit 0", disp_on, 0);
        set_ctl1(8'h00);

        // R7 ports, contrast, pwm
        wr(5'd4, 8'hFF); wr(5'd5, 8'hFF); wr(5'd6, 8'hE3); wr(5'd7, 8'h3F); wr(5'd11, 8'hF9);
        chk(port_a == 1'b1, "R7 port A", port_a, 1);
        chk(port_b == 3'h7, "R7 port B", port_b, 7);
        chk(port_c == 5'h03, "R7 port C", port_c, 3);
        chk(port_d == 5'h1F, "R7 port D", port_d, 5'h1F);
        chk(contrast == 4'h9, "R7 contrast", contrast, 9);
        wr(5'd12, 8'h5A); wr(5'd13, 8'hA5); wr(5'd14, 8'hC3);
        chk(pwm_duty == 24'hC3A55A, "R7 pwm bytes", pwm_duty, 24'hC3A55A);

        // R8 key scan
        key_timing = 3'b101; key_bits = 5'b01101;
        rd(5'd0, 8'hAD, "R8 key scan");
        key_timing = 3'b010; key_bits = 5'b10010;
        rd(5'd0, 8'h52, "R8 key scan second");

        // R9 rotary
        rot_count = 4'b1010; rd(5'd10, 8'hFA, "R9 negative count");
        rot_count = 4'b0101; rd(5'd10, 8'h05, "R9 positive count");
        rot_count = 4'b1000; rd(5'd10, 8'hF8, "R9 most negative");

        // R1 non-instruction bytes are ignored
        send(8'hA2); send(8'h05); send(8'h7F); send(8'h3F);
        chk_ptr("R1 ignored bytes");
        chk(port_b == 3'h7, "R1 ignored bytes port B", port_b, 7);
        wr(5'd2, 8'h06); mx = 4'h6;
        chk_ptr("R1 decoder still idle");

        // R10 writes with no effect
        wr(5'd15, 8'hFF); wr(5'd17, 8'h00); wr(5'd31, 8'h00); wr(5'd0, 8'hFF); wr(5'd10, 8'hFF);
        chk_ptr("R10 pointers untouched");
        chk({port_a, port_b, port_c, port_d, contrast} == {1'b1, 3'h7, 5'h03, 5'h1F, 4'h9}, "R10 ports untouched",
            {port_a, port_b, port_c, port_d, contrast}, {1'b1, 3'h7, 5'h03, 5'h1F, 4'h9});
        chk(pwm_duty == 24'hC3A55A && !disp_on, "R10 pwm and display untouched", pwm_duty, 24'hC3A55A);
        rd(5'd15, 8'h00, "R10 test register reads 0");
        rd(5'd8, 8'h00, "R10 control1 not readable");
        rd(5'd12, 8'h00, "R10 pwm not readable");
        rd(5'd31, 8'h00, "R10 undefined reads 0");

        // R12 read uses no data byte; data after write instruction is raw data
        rd(5'd0, 8'h52, "R12 read without data byte");
        send(8'hC2); send(8'h07); mx = 4'h7;
        chk_ptr("R12 next byte is instruction");
        send(8'hC3); send(8'hE1); my = 4'h1;
        chk_ptr("R12 instruction-like data byte");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R12 single-cycle response", rd_valid, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all responses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule